// File: doc/BRIEF.md
# Planar Latch Bit-Mask Write Unit

This block is the memory-access datapath of a frame buffer made of four byte-wide planes. Each address holds one byte per plane. A host read fetches all four plane bytes into a set of data latches. It returns one of two results: the byte of a selected plane, or a color-compare byte. In the compare byte, each bit says whether the planes agree with a stored color. The compare leaves out any plane whose don't-care enable is clear.

A host write builds a fresh byte for each plane according to the write mode. A shared 8-bit mask then picks, bit by bit, between that fresh byte and the latched byte. A masked bit is therefore rewritten with what the last read fetched. A plane write-enable keeps disabled planes untouched. The mask, color, don't-care and set/reset values are held in registers reached through an index/data pair. The plane storage is part of the block and is cleared at reset.

Top module: `planar_mask_unit`

## Requirements
- R1: After reset the mask reads FFh, the don't-care register reads 0Fh, the color and set/reset registers read 00h, and the latches and every plane byte are zero.
- R2: `ack` is high in exactly the cycle after a cycle with `req` high. Read data is valid on `rdata` in that same cycle.
- R3: A read (`req`=1, `we`=0) loads all four latches from the addressed plane bytes. With `rd_cmp`=0 it returns the byte of plane `rd_plane`.
- R4: A write or an idle cycle leaves the latches unchanged. Only a read reloads them.
- R5: In write modes 0, 2 and 3, each stored bit whose effective mask bit is 1 takes the fresh data bit. Each bit whose mask bit is 0 takes the latch bit of that plane. The same mask applies to all planes.
- R6: Write mode 0 (`wr_mode`=0): the fresh byte for every plane is `wdata`, and the effective mask is the mask register.
- R7: Write mode 2 (`wr_mode`=2): the fresh byte for plane p is all ones when `wdata[p]` is 1 and all zeros otherwise. The effective mask is the mask register.
- R8: Write mode 3 (`wr_mode`=3): the effective mask is the mask register ANDed with `wdata`. The fresh byte for plane p is filled with bit p of the set/reset register.
- R9: Write mode 1 (`wr_mode`=1) stores each plane's latch byte unchanged. The mask, `wdata` and set/reset have no effect.
- R10: Only planes whose `plane_en` bit is 1 are stored. A disabled plane keeps its byte whatever the mode or mask.
- R11: With `rd_cmp`=1, result bit i is 1 exactly when every plane p with don't-care bit p set has bit i equal to color bit p. When no plane is included, the result is FFh.
- R12: Register indices: 00h is set/reset (bits 3:0), 02h is color (bits 3:0), 07h is don't-care (bits 3:0, bits 7:4 read 0), and 08h is the mask. Any other index reads 00h, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Memory access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Plane byte address |
| wdata | input | 8 | Host write data |
| wr_mode | input | 2 | Write mode 0..3 |
| plane_en | input | 4 | Per-plane write enable |
| rd_cmp | input | 1 | 1 = color-compare read, 0 = plane read |
| rd_plane | input | 2 | Plane returned by a plane read |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_idx` (combinational) |
| ack | output | 1 | Access done, one cycle after `req` |
| rdata | output | 8 | Read result |

## Verification
Memory accesses take effect at the clock edge that sees `req`. `ack` and `rdata` are due one cycle later, and the plane contents and latches are updated from that same edge. The bench drives each request on a falling edge and samples `ack` and `rdata` on the next falling edge. Register writes land on the edge that sees `reg_we`. Register reads are combinational and are sampled a short delay after `reg_idx` changes. Written data is checked through the ports by reading all four planes back, with the bench model's latches reloaded on every read.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int PSEL_W = $clog2(PLANES);

  typedef enum logic [1:0] {
    WM_DIRECT = 2'd0,
    WM_LATCH  = 2'd1,
    WM_SPREAD = 2'd2,
    WM_SETRES = 2'd3
  } wmode_e;

  localparam logic [7:0] IDX_SETRES   = 8'h00;
  localparam logic [7:0] IDX_COLOR    = 8'h02;
  localparam logic [7:0] IDX_DONTCARE = 8'h07;
  localparam logic [7:0] IDX_MASK     = 8'h08;

  // Fresh byte for one plane before masking.
  function automatic logic [BYTE_W-1:0] fresh_byte(wmode_e m, logic [BYTE_W-1:0] hd,
                                                   logic sr_bit, logic nib_bit);
    case (m)
      WM_DIRECT: fresh_byte = hd;
      WM_SPREAD: fresh_byte = {BYTE_W{nib_bit}};
      WM_SETRES: fresh_byte = {BYTE_W{sr_bit}};
      default:   fresh_byte = '0;
    endcase
  endfunction

  // Mask actually applied: 1 = take fresh bit, 0 = take latch bit.
  function automatic logic [BYTE_W-1:0] eff_mask(wmode_e m, logic [BYTE_W-1:0] mask,
                                                 logic [BYTE_W-1:0] hd);
    case (m)
      WM_SETRES: eff_mask = mask & hd;
      WM_LATCH:  eff_mask = '0;
      default:   eff_mask = mask;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] merge(logic [BYTE_W-1:0] fresh,
                                              logic [BYTE_W-1:0] lat,
                                              logic [BYTE_W-1:0] m);
    merge = (fresh & m) | (lat & ~m);
  endfunction

endpackage

// File: rtl/pmw_regs.sv
module pmw_regs
  import pmw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [PLANES-1:0] setres,
  output logic [PLANES-1:0] color,
  output logic [PLANES-1:0] dcare,
  output logic [BYTE_W-1:0] mask
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setres <= '0;
      color  <= '0;
      dcare  <= '1;
      mask   <= '1;
    end else if (we) begin
      case (idx)
        IDX_SETRES:   setres <= wdata[PLANES-1:0];
        IDX_COLOR:    color  <= wdata[PLANES-1:0];
        IDX_DONTCARE: dcare  <= wdata[PLANES-1:0];
        IDX_MASK:     mask   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IDX_SETRES:   rdata[PLANES-1:0] = setres;
      IDX_COLOR:    rdata[PLANES-1:0] = color;
      IDX_DONTCARE: rdata[PLANES-1:0] = dcare;
      IDX_MASK:     rdata = mask;
      default: ;
    endcase
  end

  // R12
  dc_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_DONTCARE) |-> (rdata[7:4] == 4'h0));

  // R12
  unused_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != IDX_SETRES && idx != IDX_COLOR && idx != IDX_DONTCARE && idx != IDX_MASK)
      |-> (rdata == 8'h00));

endmodule

// File: rtl/pmw_write_path.sv
module pmw_write_path
  import pmw_pkg::*;
(
  input  wmode_e                         mode,
  input  logic [BYTE_W-1:0]              hd,
  input  logic [BYTE_W-1:0]              mask,
  input  logic [PLANES-1:0]              setres,
  input  logic [PLANES-1:0][BYTE_W-1:0]  latch,
  output logic [PLANES-1:0][BYTE_W-1:0]  wr_word,
  output logic [BYTE_W-1:0]              mask_used
);

  assign mask_used = eff_mask(mode, mask, hd);

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] fresh;
    assign fresh      = fresh_byte(mode, hd, setres[p], hd[p]);
    assign wr_word[p] = merge(fresh, latch[p], mask_used);
  end

endmodule

// File: rtl/pmw_read_path.sv
module pmw_read_path
  import pmw_pkg::*;
(
  input  logic [PLANES-1:0][BYTE_W-1:0] word,
  input  logic [PLANES-1:0]             color,
  input  logic [PLANES-1:0]             dcare,
  input  logic [PSEL_W-1:0]             plane_sel,
  input  logic                          cmp,
  output logic [BYTE_W-1:0]             result,
  output logic [BYTE_W-1:0]             cmp_byte
);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic [PLANES-1:0] column;
    for (genvar p = 0; p < PLANES; p++) begin : g_col
      assign column[p] = word[p][i];
    end
    // a plane disagrees only if it is included and differs from color
    assign cmp_byte[i] = ~|((column ^ color) & dcare);
  end

  assign result = cmp ? cmp_byte : word[plane_sel];

endmodule

// File: rtl/planar_mask_unit.sv
module planar_mask_unit
  import pmw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [1:0]        wr_mode,
  input  logic [3:0]        plane_en,
  input  logic              rd_cmp,
  input  logic [1:0]        rd_plane,
  input  logic              reg_we,
  input  logic [7:0]        reg_idx,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ack,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [PLANES-1:0][BYTE_W-1:0] mem [DEPTH];
  logic [PLANES-1:0][BYTE_W-1:0] latch_q;
  logic [PLANES-1:0][BYTE_W-1:0] cur_word;
  logic [PLANES-1:0][BYTE_W-1:0] wr_word;
  logic [PLANES-1:0]             setres, color, dcare;
  logic [BYTE_W-1:0]             mask, mask_used, rd_result, cmp_byte;
  wmode_e                        mode;

  // named events for the assertions
  logic rd_evt, wr_evt;
  assign rd_evt   = req && !we;
  assign wr_evt   = req && we;
  assign mode     = wmode_e'(wr_mode);
  assign cur_word = mem[addr];

  pmw_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .idx    (reg_idx),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .setres (setres),
    .color  (color),
    .dcare  (dcare),
    .mask   (mask)
  );

  pmw_write_path u_wr (
    .mode      (mode),
    .hd        (wdata),
    .mask      (mask),
    .setres    (setres),
    .latch     (latch_q),
    .wr_word   (wr_word),
    .mask_used (mask_used)
  );

  pmw_read_path u_rd (
    .word      (cur_word),
    .color     (color),
    .dcare     (dcare),
    .plane_sel (rd_plane),
    .cmp       (rd_cmp),
    .result    (rd_result),
    .cmp_byte  (cmp_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      rdata   <= '0;
      latch_q <= '0;
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      ack <= req;
      if (rd_evt) begin
        latch_q <= cur_word;
        rdata   <= rd_result;
      end
      if (wr_evt) begin
        for (int p = 0; p < PLANES; p++)
          if (plane_en[p]) mem[addr][p] <= wr_word[p];
      end
    end
  end

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);

  // R2
  ack_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ack);

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(latch_q));

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> (latch_q == $past(cur_word)));

  // R11
  none_included_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && rd_cmp && dcare == '0) |=> (rdata == 8'hFF));

  for (genvar p = 0; p < PLANES; p++) begin : g_chk
    // R5
    masked_bits_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && mode != WM_LATCH) |-> (((wr_word[p] ^ latch_q[p]) & ~mask) == '0));
    // R9
    latch_mode_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && mode == WM_LATCH) |-> (wr_word[p] == latch_q[p]));
  end

endmodule

// File: tb/planar_mask_unit_tb.sv
module planar_mask_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 4;
  localparam int NADDR      = 1 << AW;
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, we, rd_cmp, reg_we;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, reg_idx, reg_wdata, reg_rdata, rdata;
  logic [1:0]    wr_mode, rd_plane;
  logic [3:0]    plane_en;
  logic          ack;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // bench model
  logic [7:0] m_mem [NADDR][4];
  logic [7:0] m_lat [4];
  logic [7:0] m_mask;
  logic [3:0] m_dc, m_col, m_sr;

  planar_mask_unit #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .wr_mode(wr_mode), .plane_en(plane_en), .rd_cmp(rd_cmp), .rd_plane(rd_plane),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack(ack), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, act cycles=%0d exp<=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // register access (entered at a falling edge)
  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (idx)
      8'h00: m_sr   = d[3:0];
      8'h02: m_col  = d[3:0];
      8'h07: m_dc   = d[3:0];
      8'h08: m_mask = d;
      default: ;
    endcase
  endtask

  task automatic reg_rd_check(string tag, logic [7:0] idx, logic [7:0] exp);
    reg_idx = idx;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] exp_cmp(logic [AW-1:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (m_dc[p] && (m_mem[a][p][i] != m_col[p])) r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic do_read(string tag, logic [AW-1:0] a, logic [1:0] pl, logic cmpm);
    logic [7:0] exp;
    exp = cmpm ? exp_cmp(a) : m_mem[a][pl];
    req = 1'b1; we = 1'b0; addr = a; rd_plane = pl; rd_cmp = cmpm;
    @(negedge clk);
    req = 1'b0;
    check("R2 ack after read", {7'b0, ack}, 8'h01);
    check(tag, rdata, exp);
    for (int p = 0; p < 4; p++) m_lat[p] = m_mem[a][p];
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [1:0] md, logic [7:0] d, logic [3:0] en);
    req = 1'b1; we = 1'b1; addr = a; wr_mode = md; wdata = d; plane_en = en;
    @(negedge clk);
    req = 1'b0;
    check("R2 ack after write", {7'b0, ack}, 8'h01);
    for (int p = 0; p < 4; p++) begin
      logic [7:0] fr, mk;
      if (!en[p]) continue;
      case (md)
        2'd0: begin fr = d; mk = m_mask; end
        2'd2: begin fr = d[p] ? 8'hFF : 8'h00; mk = m_mask; end
        2'd3: begin fr = m_sr[p] ? 8'hFF : 8'h00; mk = m_mask & d; end
        default: begin fr = 8'h00; mk = 8'h00; end
      endcase
      m_mem[a][p] = (fr & mk) | (m_lat[p] & ~mk);
    end
  endtask

  task automatic read_back(string tag, logic [AW-1:0] a);
    for (int p = 0; p < 4; p++) do_read(tag, a, p[1:0], 1'b0);
  endtask

  initial begin
    string tag;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; wr_mode = '0;
    plane_en = '0; rd_cmp = 1'b0; rd_plane = '0; reg_we = 1'b0; reg_idx = '0;
    reg_wdata = '0;
    for (int a = 0; a < NADDR; a++)
      for (int p = 0; p < 4; p++) m_mem[a][p] = 8'h00;
    for (int p = 0; p < 4; p++) m_lat[p] = 8'h00;
    m_mask = 8'hFF; m_dc = 4'hF; m_col = 4'h0; m_sr = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 ack idle after reset", {7'b0, ack}, 8'h00);
    reg_rd_check("R1 mask reset", 8'h08, 8'hFF);
    reg_rd_check("R1 dontcare reset", 8'h07, 8'h0F);
    reg_rd_check("R1 color reset", 8'h02, 8'h00);
    reg_rd_check("R1 setres reset", 8'h00, 8'h00);
    // R1: latches zero - write through a half mask before any read
    reg_wr(8'h08, 8'h0F);
    do_write(4'd5, 2'd0, 8'hFF, 4'hF);
    read_back("R1 latches zero at reset", 4'd5);
    read_back("R1 planes zero at reset", 4'd9);

    // R12 register map and unused indices
    reg_wr(8'h05, 8'hAA);
    reg_wr(8'h07, 8'hF6);
    reg_rd_check("R12 dontcare upper bits zero", 8'h07, 8'h06);
    reg_rd_check("R12 unused index reads zero", 8'h05, 8'h00);
    reg_rd_check("R12 unused write no effect on mask", 8'h08, 8'h0F);
    reg_wr(8'h00, 8'hF9);
    reg_rd_check("R12 setres low nibble", 8'h00, 8'h09);
    reg_wr(8'h02, 8'h3C);
    reg_rd_check("R12 color low nibble", 8'h02, 8'h0C);

    // R6 R10 fill every address plane by plane with full mask
    reg_wr(8'h08, 8'hFF);
    for (int a = 0; a < NADDR; a++)
      for (int p = 0; p < 4; p++)
        do_write(a[AW-1:0], 2'd0, 8'(a * 37 + p * 91 + 5), 4'(1 << p));
    for (int a = 0; a < NADDR; a++) read_back("R6 R10 R3 fill readback", a[AW-1:0]);

    // R4 latches survive writes; mode 1 copies them (R9)
    do_read("R3 latch source read", 4'd3, 2'd0, 1'b0);
    reg_wr(8'h08, 8'h00);
    do_write(4'd7, 2'd0, 8'h5A, 4'hF);
    do_write(4'd11, 2'd1, 8'hC3, 4'hF);
    read_back("R4 R9 latch copy after write", 4'd11);

    // R11 no plane included
    reg_wr(8'h07, 8'h00);
    for (int a = 0; a < NADDR; a++) do_read("R11 no plane included", a[AW-1:0], 2'd0, 1'b1);

    // R11 sweep of color and don't-care over one address
    for (int dc = 0; dc < 16; dc++) begin
      reg_wr(8'h07, 8'(dc));
      for (int c = 0; c < 16; c++) begin
        reg_wr(8'h02, 8'(c));
        do_read("R11 color compare", 4'd6, 2'd0, 1'b1);
      end
    end

    // R5 R6 R7 R8 R9 R10 mixed sweep
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a, b;
      logic [1:0] md;
      a  = AW'($urandom_range(0, NADDR-1));
      b  = AW'($urandom_range(0, NADDR-1));
      md = 2'(n % 4);
      reg_wr(8'h08, 8'($urandom_range(0, 255)));
      reg_wr(8'h00, 8'($urandom_range(0, 15)));
      do_read("R3 plane read", b, 2'($urandom_range(0, 3)), 1'b0);
      do_write(a, md, 8'($urandom_range(0, 255)), 4'($urandom_range(0, 15)));
      case (md)
        2'd0: tag = "R5 R6 R10 mode0 masked write";
        2'd1: tag = "R9 R10 mode1 latch write";
        2'd2: tag = "R5 R7 R10 mode2 spread write";
        default: tag = "R5 R8 R10 mode3 setres write";
      endcase
      read_back(tag, a);
      reg_wr(8'h07, 8'($urandom_range(0, 15)));
      reg_wr(8'h02, 8'($urandom_range(0, 15)));
      do_read("R11 compare after writes", a, 2'd0, 1'b1);
    end

    summary();
  end

endmodule